// File: doc/BRIEF.md
# Per-Area Bus Cycle Wait Controller

This block decides how many clock states each bus access lasts. The bus sequencer raises a start strobe together with the target area (0 to 7), the space type, the direction, the DRAM-mode flag for area 1 and a refresh flag. The block then holds `busy_o` for the length of the access and pulses `done_o` for one clock. The sequencer uses that pulse to advance. The length depends on the space type, on which area group is targeted, and on a per-area sampling bit. That bit adds a second base state and also enables sampling of the external active-low wait line.

A 16-bit wait control register holds one sampling bit per area in bits 15:8, with area n at bit 8+n. Bit 1 sets the pitch of DRAM writes to area 1. Bits 7:2 and bit 0 are reserved: they always read 1 and ignore writes. Refresh cycles ignore the wait line and last for a programmed count. Writing a prohibited setting is corrected automatically and latches a sticky error flag that can be read back.

One access is in flight at a time. An access accepted at rising edge k and lasting N states holds `busy_o` high from edge k to edge k+N. It drives `done_o` high for the clock that follows edge k+N. A new start is accepted from edge k+N+1 onward.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset, `reg_rdata_o` reads 16'hFFFF, and `busy_o`, `done_o` and `cfg_err_o` are 0.
- R2: A register write stores bits 15:8, where bit 8+n is the sampling bit of area n. Bits 7:2 and bit 0 always read 1, whatever value is written.
- R3: `space_i` = 3 (on-chip memory) gives exactly 1 state, and `space_i` = 2 (on-chip peripheral) gives exactly 3 states. Neither samples the wait line.
- R4: `space_i` = 1 (multiplexed address/data I/O) gives 4 base states, and the wait line is always sampled, whatever the area bit is.
- R5: On `space_i` = 0, a read to area 1, 3, 4, 5 or 7 lasts 1 state when that area's bit is 0. When the bit is 1, it lasts 2 base states with wait sampling. Area 1 follows this rule for reads in DRAM mode too.
- R6: On `space_i` = 0, a read to area 0, 2 or 6 lasts 1 + (`long_wait_i` + 1) base states. The wait line is sampled only when that area's bit is 1.
- R7: An external write to area 1 with `dram_en_i` = 1 lasts 1 state if register bit 1 is 0, and 2 base states with wait sampling if bit 1 is 1. With `dram_en_i` = 0, it always lasts 2 base states with wait sampling.
- R8: An external write to any area other than 1 follows the same rule as a read to that area.
- R9: With `refresh_i` = 1, the access lasts 2 + `rfsh_wait_i` states and the wait line is ignored. This takes priority over space type and area.
- R10: A write with bit 1 = 0 while `dram_en_i` = 0 stores 1 in bit 1 and sets `cfg_err_o`. `cfg_err_o` stays set until reset.
- R11: `wait_ni` passes through a two-flop synchronizer. It is sampled at the edge that ends the last base state. Each sample that finds it low (asserted) adds one state, and sampling repeats until a high sample is seen.
- R12: A start while `busy_o` is high is ignored. `done_o` lasts exactly one clock, in the cycle after the last state, and `busy_o` is low while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Access start strobe |
| area_i | input | 3 | Target area number |
| space_i | input | 2 | 0 external, 1 multiplexed I/O, 2 on-chip peripheral, 3 on-chip memory |
| write_i | input | 1 | 1 for write, 0 for read |
| dram_en_i | input | 1 | Area 1 operates as DRAM |
| refresh_i | input | 1 | Access is a refresh cycle |
| wait_ni | input | 1 | External wait request, active low, asynchronous |
| long_wait_i | input | 2 | Long-wait count for areas 0, 2, 6 (adds 1 to 4 states) |
| rfsh_wait_i | input | 2 | Refresh wait count |
| reg_we_i | input | 1 | Wait control register write enable |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read value |
| cfg_err_o | output | 1 | Sticky prohibited-setting flag |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock access completion pulse |

## Verification
A wrong length selection or a wrong count shows up as `done_o` arriving early or late by whole clocks on the very access that hits it. So every vector compares the measured state count against a count derived from the rules. Wait-line faults are separated from base-length faults by releasing the line at a known cycle, so that the expected number of extension states follows from the two-flop latency. A corrupted register bit or error flag stays hidden until the matching area is accessed or the register is read. For that reason the bench reads the register right after each directed write.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int unsigned CNT_W  = 3;
  localparam int unsigned AREA_W = 3;
  localparam int unsigned N_AREA = 1 << AREA_W;
  localparam int unsigned REG_W  = 16;

  typedef enum logic [1:0] {
    SP_EXT    = 2'd0,
    SP_MUXIO  = 2'd1,
    SP_PERIPH = 2'd2,
    SP_ONCHIP = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_EXT  = 2'd2
  } seq_e;

  typedef struct packed {
    logic [CNT_W-1:0] base;
    logic             samp;
  } len_t;
endpackage

// File: rtl/bwc_sync.sv
module bwc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/bwc_cfg_reg.sv
module bwc_cfg_reg
  import bwc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              dram_en_i,
  output logic [N_AREA-1:0] rd_bits_o,
  output logic              ww_o,
  output logic              err_o,
  output logic [REG_W-1:0]  rdata_o
);
  localparam int unsigned RSVD_W = REG_W - N_AREA - 2;

  logic [N_AREA-1:0] rd_q;
  logic              ww_q;
  logic              err_q;
  logic              bad_wr;

  // short pitch is only legal when area 1 runs as DRAM
  assign bad_wr = we_i && !wdata_i[1] && !dram_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '1;
      ww_q  <= 1'b1;
      err_q <= 1'b0;
    end else if (we_i) begin
      rd_q <= wdata_i[REG_W-1 -: N_AREA];
      ww_q <= bad_wr ? 1'b1 : wdata_i[1];
      if (bad_wr) err_q <= 1'b1;
    end
  end

  assign rd_bits_o = rd_q;
  assign ww_o      = ww_q;
  assign err_o     = err_q;
  assign rdata_o   = {rd_q, {RSVD_W{1'b1}}, ww_q, 1'b1};
endmodule

// File: rtl/bwc_len_calc.sv
module bwc_len_calc
  import bwc_pkg::*;
#(
  parameter logic [N_AREA-1:0] LONG_MASK = 8'b0100_0101,
  parameter int unsigned       DRAM_AREA = 1
) (
  input  logic [AREA_W-1:0] area_i,
  input  logic [1:0]        space_i,
  input  logic              write_i,
  input  logic              dram_en_i,
  input  logic              refresh_i,
  input  logic [1:0]        long_wait_i,
  input  logic [1:0]        rfsh_wait_i,
  input  logic [N_AREA-1:0] rd_bits_i,
  input  logic              ww_i,
  output len_t              len_o
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);
  localparam logic [CNT_W-1:0] THREE = CNT_W'(3);
  localparam logic [CNT_W-1:0] FOUR  = CNT_W'(4);

  logic is_dram_wr;
  logic area_bit;

  assign is_dram_wr = write_i && (area_i == AREA_W'(DRAM_AREA));
  assign area_bit   = rd_bits_i[area_i];

  always_comb begin
    len_o = '{base: ONE, samp: 1'b0};
    if (refresh_i) begin
      len_o.base = TWO + CNT_W'(rfsh_wait_i);
    end else begin
      unique case (space_e'(space_i))
        SP_ONCHIP: len_o.base = ONE;
        SP_PERIPH: len_o.base = THREE;
        SP_MUXIO:  len_o = '{base: FOUR, samp: 1'b1};
        default: begin
          if (is_dram_wr) begin
            if (dram_en_i && !ww_i) len_o.base = ONE;
            else                    len_o = '{base: TWO, samp: 1'b1};
          end else if (LONG_MASK[area_i]) begin
            len_o.base = TWO + CNT_W'(long_wait_i);
            len_o.samp = area_bit;
          end else if (area_bit) begin
            len_o = '{base: TWO, samp: 1'b1};
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
  import bwc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  len_t len_i,
  input  logic wait_act_i,
  output logic busy_o,
  output logic done_o
);
  seq_e             state_q;
  logic [CNT_W-1:0] rem_q;
  logic             samp_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      samp_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          rem_q   <= len_i.base;
          samp_q  <= len_i.samp;
          state_q <= ST_BASE;
        end
        ST_BASE: begin
          if (rem_q > CNT_W'(1)) begin
            rem_q <= rem_q - CNT_W'(1);
          end else if (samp_q && wait_act_i) begin
            state_q <= ST_EXT;
          end else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_EXT: if (!wait_act_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AREA_W-1:0] area_i,
  input  logic [1:0]        space_i,
  input  logic              write_i,
  input  logic              dram_en_i,
  input  logic              refresh_i,
  input  logic              wait_ni,
  input  logic [1:0]        long_wait_i,
  input  logic [1:0]        rfsh_wait_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              cfg_err_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [N_AREA-1:0] rd_bits;
  logic              ww;
  logic              wait_act;
  len_t              len;

  bwc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (~wait_ni),
    .q_o    (wait_act)
  );

  bwc_cfg_reg i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .dram_en_i (dram_en_i),
    .rd_bits_o (rd_bits),
    .ww_o      (ww),
    .err_o     (cfg_err_o),
    .rdata_o   (reg_rdata_o)
  );

  bwc_len_calc i_len (
    .area_i      (area_i),
    .space_i     (space_i),
    .write_i     (write_i),
    .dram_en_i   (dram_en_i),
    .refresh_i   (refresh_i),
    .long_wait_i (long_wait_i),
    .rfsh_wait_i (rfsh_wait_i),
    .rd_bits_i   (rd_bits),
    .ww_i        (ww),
    .len_o       (len)
  );

  bwc_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .len_i      (len),
    .wait_act_i (wait_act),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/bwc_chk.sv
module bwc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [1:0]  space_i,
  input logic        dram_en_i,
  input logic        refresh_i,
  input logic        reg_we_i,
  input logic [15:0] reg_wdata_i,
  input logic [15:0] reg_rdata_o,
  input logic        cfg_err_o,
  input logic        busy_o,
  input logic        done_o
);
  p_done_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_accept_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_onchip_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && space_i == 2'd3 && !refresh_i) |=> ##1 done_o);

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  p_forbid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_wdata_i[1] && !dram_en_i) |=> (cfg_err_o && reg_rdata_o[1]));

  p_area_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> (reg_rdata_o[15:8] == $past(reg_wdata_i[15:8])));
endmodule

bind bus_wait_ctrl bwc_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .space_i     (space_i),
  .dram_en_i   (dram_en_i),
  .refresh_i   (refresh_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .cfg_err_o   (cfg_err_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/test_bus_wait_ctrl.sv
`timescale 1ns/1ps
module test_bus_wait_ctrl;
  localparam real CLK_P = 5.0;

  typedef struct packed {
    logic [15:0] cfg;
    logic [1:0]  sp;
    logic [2:0]  area;
    logic        wr;
    logic        dram;
    logic        rfsh;
    logic [1:0]  lw;
    logic [1:0]  rw;
    logic [3:0]  rel;
  } vec_t;

  localparam int NV = 18;
  // cfg, space, area, wr, dram, rfsh, long, rfsh_wait, wait release cycle
  localparam vec_t VECS [NV] = '{
    '{16'hFFFF, 2'd3, 3'd3, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd4},
    '{16'hFFFF, 2'd2, 3'd5, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd4},
    '{16'h0000, 2'd1, 3'd0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 4'd0},
    '{16'h0000, 2'd1, 3'd2, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 4'd5},
    '{16'hFFFF, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd0},
    '{16'hF7FF, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd5},
    '{16'hFFFF, 2'd0, 3'd5, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd4},
    '{16'hFEFF, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 4'd5},
    '{16'hFFFF, 2'd0, 3'd6, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd6},
    '{16'hFFFF, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 4'd3},
    '{16'hFFFD, 2'd0, 3'd1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 4'd5},
    '{16'hFFFF, 2'd0, 3'd1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 4'd4},
    '{16'hFFFF, 2'd0, 3'd1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd3},
    '{16'hFDFF, 2'd0, 3'd1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 4'd4},
    '{16'h7FFF, 2'd0, 3'd7, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd4},
    '{16'hFFFF, 2'd0, 3'd3, 1'b0, 1'b0, 1'b1, 2'd0, 2'd2, 4'd6},
    '{16'hFFFF, 2'd3, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 4'd6},
    '{16'hFFFF, 2'd0, 3'd4, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd2}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  area_i = '0;
  logic [1:0]  space_i = '0;
  logic        write_i = 1'b0;
  logic        dram_en_i = 1'b0;
  logic        refresh_i = 1'b0;
  logic        wait_ni = 1'b1;
  logic [1:0]  long_wait_i = '0;
  logic [1:0]  rfsh_wait_i = '0;
  logic        reg_we_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        cfg_err_o;
  logic        busy_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  bus_wait_ctrl i_bus_wait_ctrl (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected state count from the requirements
  function automatic int exp_len(input vec_t v);
    int  b;
    bit  s;
    bit  abit;
    bit  ww_eff;
    int  extra;
    abit   = v.cfg[8 + v.area];
    ww_eff = v.cfg[1] | ~v.dram;
    s = 1'b0;
    if (v.rfsh) b = 2 + v.rw;                           // R9
    else if (v.sp == 2'd3) b = 1;                       // R3
    else if (v.sp == 2'd2) b = 3;                       // R3
    else if (v.sp == 2'd1) begin b = 4; s = 1'b1; end   // R4
    else if (v.wr && v.area == 3'd1) begin              // R7
      if (v.dram && !ww_eff) b = 1;
      else begin b = 2; s = 1'b1; end
    end else if (v.area == 3'd0 || v.area == 3'd2 || v.area == 3'd6) begin
      b = 2 + v.lw; s = abit;                           // R6
    end else begin                                      // R5, R8
      b = abit ? 2 : 1; s = abit;
    end
    // R11: two-flop latency, release at cycle rel
    extra = int'(v.rel) + 2 - b;
    if (!s || extra < 0) extra = 0;
    return b + extra;
  endfunction

  task automatic reg_write(input logic [15:0] d, input logic dram);
    @(negedge clk_i);
    dram_en_i   = dram;
    reg_we_i    = 1'b1;
    reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i    = 1'b0;
  endtask

  task automatic run_access(input vec_t v, output int n);
    int idx;
    n = -1;
    if (v.rel != 0) begin
      wait_ni = 1'b0;
      repeat (3) @(negedge clk_i);
    end
    @(negedge clk_i);
    space_i = v.sp; area_i = v.area; write_i = v.wr; dram_en_i = v.dram;
    refresh_i = v.rfsh; long_wait_i = v.lw; rfsh_wait_i = v.rw;
    if (v.rel == 0) wait_ni = 1'b1;
    start_i = 1'b1;
    idx = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      idx++;
      if (idx == int'(v.rel)) wait_ni = 1'b1;
      if (done_o) begin
        n = idx - 1;
        break;
      end
    end
    wait_ni = 1'b1;
    refresh_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    int dn;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 rdata", int'(reg_rdata_o), 16'hFFFF);
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 err", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      reg_write(VECS[i].cfg, VECS[i].dram);
      run_access(VECS[i], n);
      check($sformatf("R3-R11 vector %0d length", i), n, exp_len(VECS[i]));
    end
    check("R10 no error yet", int'(cfg_err_o), 0);

    // R2 reserved bits read 1, area bits stored
    reg_write(16'h0000, 1'b1);
    check("R2 all-zero write", int'(reg_rdata_o), 16'h00FD);
    reg_write(16'hA5FE, 1'b1);
    check("R2 mixed write", int'(reg_rdata_o), 16'hA5FF);

    // R10 prohibited write corrected and latched
    reg_write(16'h3C00, 1'b0);
    check("R10 bit1 forced", int'(reg_rdata_o), 16'h3CFF);
    check("R10 err set", int'(cfg_err_o), 1);
    reg_write(16'hFFFD, 1'b1);
    check("R10 legal short pitch", int'(reg_rdata_o), 16'hFFFD);
    check("R10 err sticky", int'(cfg_err_o), 1);

    // R12 start while busy ignored; done one clock
    @(negedge clk_i);
    space_i = 2'd1; area_i = 3'd0; write_i = 1'b0; refresh_i = 1'b0;
    wait_ni = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    space_i = 2'd3;
    check("R12 busy after start", int'(busy_o), 1);
    @(negedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    dn = 0;
    n = -1;
    for (int k = 0; k < 10; k++) begin
      if (done_o) begin
        dn++;
        if (n < 0) n = k;
      end
      @(negedge clk_i);
    end
    check("R12 first done timing", n, 2);
    check("R12 single done pulse", dn, 1);
    check("R12 idle at end", int'(busy_o), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule